// File: doc/BRIEF.md
# Single-Issue Processor to Avalon-MM Memory Master

This block sits between the memory port of a stack processor and an Avalon-MM master port. The processor starts at most one read or write at a time. It shows the address and write data for a single clock only, then keeps running its own code. The bridge latches the request on that cycle and drives the Avalon command from registers. It keeps the command steady for as long as the slave stalls it with waitrequest.

The bridge does not hand back a plain done flag. It gives the processor a small cycle countdown, so the processor can plan to restart its pipeline before the result lands. Read data is captured and then held steady until a later read replaces it, so the processor may pick it up at any time. One parameter selects how read data is sampled. In latency-aware mode, data is taken on the readdatavalid strobe. Otherwise it is taken in the cycle where read is high and waitrequest is low.

Top module: `mem_bridge_master`

## Requirements
- R1: A request pulse (`cpu_rd` or `cpu_wr` high for one cycle) seen while `cpu_ready_cnt` is 0 is taken at that clock edge. In the next cycle, `av_address` and `av_writedata` carry the values sampled at that edge, with `av_read` (for a read) or `av_write` (for a write) high.
- R2: While `av_read` or `av_write` is high and `av_waitrequest` is high, the next cycle keeps the same strobe high and leaves `av_address` and `av_writedata` unchanged.
- R3: `cpu_ready_cnt` (2 bits, unsigned) reads 3 in the first cycle after a request is taken. After each later cycle in which waitrequest stalls the command, it drops by one, but never below 1.
- R4: In the cycle after the command is accepted (strobe high and waitrequest low), both strobes are low. For a write, and for a read in non-latency-aware mode, `cpu_ready_cnt` is 0 in that cycle.
- R5: With `LATENCY_AWARE` = 0, the read result is the value of `av_readdata` in the cycle where `av_read` is high and `av_waitrequest` is low.
- R6: With `LATENCY_AWARE` = 1, the read result is the value of `av_readdata` in the cycle where `av_readdatavalid` is high. `cpu_ready_cnt` reads 1 from command acceptance until that cycle and reads 0 in the cycle after it.
- R7: `cpu_rdata` keeps its value through idle cycles and write transactions until the next read result is captured.
- R8: A request that arrives while `cpu_ready_cnt` is nonzero is ignored. The bus keeps the running transaction's address, and no second transaction starts.
- R9: If `cpu_rd` and `cpu_wr` are both high in an accepted cycle, a read is performed and `av_write` stays low. `av_read` and `av_write` are never both high.
- R10: While `rst` is high, and in the first cycle after it, both strobes are low, `cpu_ready_cnt` is 0 and `cpu_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_rd | input | 1 | Read request pulse from processor |
| cpu_wr | input | 1 | Write request pulse from processor |
| cpu_addr | input | ADDR_W | Address, valid in the request cycle only |
| cpu_wdata | input | DATA_W | Write data, valid in the request cycle only |
| cpu_rdata | output | DATA_W | Last captured read result, held |
| cpu_ready_cnt | output | 2 | Cycles until the result is available; 0 = done or idle |
| av_address | output | ADDR_W | Avalon address (registered) |
| av_writedata | output | DATA_W | Avalon write data (registered) |
| av_read | output | 1 | Avalon read strobe (registered) |
| av_write | output | 1 | Avalon write strobe (registered) |
| av_waitrequest | input | 1 | Slave stall |
| av_readdata | input | DATA_W | Slave read data |
| av_readdatavalid | input | 1 | Slave read data valid (used when LATENCY_AWARE = 1) |

## Verification
The strobes and the bus address appear one cycle after the request edge, and the countdown follows it exactly. It shows 3 first, then drops once per stalled cycle to a floor of 1, and reaches 0 one cycle after acceptance. In latency-aware mode it reaches 0 one cycle after the valid strobe. Each directed task sets the slave's stall count and data delay, then works out the expected countdown, strobe and address for every cycle offset from the request edge. It samples each of these on the falling edge in between. Two copies of the bridge, one in each sampling mode, see the same stimulus. The slave drives different data during the command cycle and during the valid pulse, so each copy's captured value shows which cycle it sampled.

// File: rtl/bridge_pkg.sv
package bridge_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CMD  = 2'd1,
    ST_DATA = 2'd2
  } seq_state_t;

  localparam int CNT_W = 2;
  localparam logic [CNT_W-1:0] CNT_START = 2'd3;
  localparam logic [CNT_W-1:0] CNT_FLOOR = 2'd1;
endpackage

// File: rtl/brg_req_latch.sv
module brg_req_latch #(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_wdata,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (load) begin
      addr_q  <= in_addr;
      wdata_q <= in_wdata;
    end
  end
endmodule

// File: rtl/brg_sequencer.sv
module brg_sequencer
  import bridge_pkg::*;
#(
  parameter bit LATENCY_AWARE = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_rd,
  input  logic             req_wr,
  input  logic             waitreq,
  input  logic             rdv,
  output logic             load,
  output logic             capture,
  output logic             rd_q,
  output logic             wr_q,
  output logic [CNT_W-1:0] cnt_q
);
  seq_state_t state_q;
  logic       accept;

  always_comb begin
    accept = (state_q == ST_IDLE) && (req_rd || req_wr);
    load   = accept;
  end

  generate
    if (LATENCY_AWARE) begin : g_rdv
      assign capture = (state_q == ST_DATA) && rdv;
    end else begin : g_plain
      logic unused_rdv;
      assign unused_rdv = rdv;
      assign capture = (state_q == ST_CMD) && rd_q && !waitreq;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      rd_q    <= 1'b0;
      wr_q    <= 1'b0;
      cnt_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            rd_q    <= req_rd;
            wr_q    <= !req_rd;
            cnt_q   <= CNT_START;
            state_q <= ST_CMD;
          end
        end
        ST_CMD: begin
          if (!waitreq) begin
            rd_q <= 1'b0;
            wr_q <= 1'b0;
            if (LATENCY_AWARE && rd_q) begin
              cnt_q   <= CNT_FLOOR;
              state_q <= ST_DATA;
            end else begin
              cnt_q   <= '0;
              state_q <= ST_IDLE;
            end
          end else if (cnt_q > CNT_FLOOR) begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        ST_DATA: begin
          if (rdv) begin
            cnt_q   <= '0;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assert_strobe_held_R2: assert property (@(posedge clk) disable iff (rst)
    ((rd_q || wr_q) && waitreq) |=> (rd_q == $past(rd_q) && wr_q == $past(wr_q)));

  assert_count_start_R3: assert property (@(posedge clk) disable iff (rst)
    (req_rd || req_wr) && cnt_q == '0 |=> cnt_q == CNT_START);

  assert_idle_quiet_R4: assert property (@(posedge clk) disable iff (rst)
    cnt_q == '0 |-> (!rd_q && !wr_q));

  assert_one_strobe_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rd_q, wr_q}));
endmodule

// File: rtl/brg_rdata_hold.sv
module brg_rdata_hold #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              capture,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);
  always_ff @(posedge clk) begin
    if (rst)          dout <= '0;
    else if (capture) dout <= din;
  end
endmodule

// File: rtl/mem_bridge_master.sv
module mem_bridge_master
  import bridge_pkg::*;
#(
  parameter int ADDR_W        = 24,
  parameter int DATA_W        = 32,
  parameter bit LATENCY_AWARE = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_rd,
  input  logic              cpu_wr,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic [CNT_W-1:0]  cpu_ready_cnt,
  output logic [ADDR_W-1:0] av_address,
  output logic [DATA_W-1:0] av_writedata,
  output logic              av_read,
  output logic              av_write,
  input  logic              av_waitrequest,
  input  logic [DATA_W-1:0] av_readdata,
  input  logic              av_readdatavalid
);
  logic load;
  logic capture;

  brg_sequencer #(.LATENCY_AWARE(LATENCY_AWARE)) u_seq (
    .clk     (clk),
    .rst     (rst),
    .req_rd  (cpu_rd),
    .req_wr  (cpu_wr),
    .waitreq (av_waitrequest),
    .rdv     (av_readdatavalid),
    .load    (load),
    .capture (capture),
    .rd_q    (av_read),
    .wr_q    (av_write),
    .cnt_q   (cpu_ready_cnt)
  );

  brg_req_latch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_latch (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .in_addr  (cpu_addr),
    .in_wdata (cpu_wdata),
    .addr_q   (av_address),
    .wdata_q  (av_writedata)
  );

  brg_rdata_hold #(.DATA_W(DATA_W)) u_hold (
    .clk     (clk),
    .rst     (rst),
    .capture (capture),
    .din     (av_readdata),
    .dout    (cpu_rdata)
  );

  assert_bus_stable_R2: assert property (@(posedge clk) disable iff (rst)
    ((av_read || av_write) && av_waitrequest) |=>
      ($stable(av_address) && $stable(av_writedata)));

  assert_idle_keeps_data_R7: assert property (@(posedge clk) disable iff (rst)
    cpu_ready_cnt == '0 |=> $stable(cpu_rdata));

  assert_busy_ignores_req_R8: assert property (@(posedge clk) disable iff (rst)
    (cpu_ready_cnt != '0 && !av_read && !av_write) |=> (!av_read && !av_write));
endmodule

// File: tb/sim_mem_bridge_master.sv
module sim_mem_bridge_master;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 24;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_rd = 1'b0, req_wr = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;

  logic [DW-1:0] a_rdata, b_rdata;
  logic [1:0]    a_cnt, b_cnt;
  logic [AW-1:0] a_addr, b_addr;
  logic [DW-1:0] a_wd, b_wd;
  logic          a_rd, a_wr, b_rd, b_wr;

  logic          wreq, rdv;
  logic [DW-1:0] rdata_bus;
  int            wleft = 0;
  int            rlat = 1;
  int            rdv_cnt = 0;
  logic [DW-1:0] val_a = '0, val_b = '0;

  int nchk = 0;
  int nbad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // u0: latency-aware copy; u1: waitrequest-only copy
  mem_bridge_master #(.ADDR_W(AW), .DATA_W(DW), .LATENCY_AWARE(1'b1)) u0 (
    .clk(clk), .rst(rst), .cpu_rd(req_rd), .cpu_wr(req_wr), .cpu_addr(req_addr),
    .cpu_wdata(req_wdata), .cpu_rdata(a_rdata), .cpu_ready_cnt(a_cnt),
    .av_address(a_addr), .av_writedata(a_wd), .av_read(a_rd), .av_write(a_wr),
    .av_waitrequest(wreq), .av_readdata(rdata_bus), .av_readdatavalid(rdv));

  mem_bridge_master #(.ADDR_W(AW), .DATA_W(DW), .LATENCY_AWARE(1'b0)) u1 (
    .clk(clk), .rst(rst), .cpu_rd(req_rd), .cpu_wr(req_wr), .cpu_addr(req_addr),
    .cpu_wdata(req_wdata), .cpu_rdata(b_rdata), .cpu_ready_cnt(b_cnt),
    .av_address(b_addr), .av_writedata(b_wd), .av_read(b_rd), .av_write(b_wr),
    .av_waitrequest(wreq), .av_readdata(rdata_bus), .av_readdatavalid(rdv));

  // slave model: wleft stall cycles, then data valid rlat cycles after acceptance
  assign wreq      = (a_rd || a_wr) && (wleft != 0);
  assign rdv       = (rdv_cnt == 1);
  assign rdata_bus = rdv ? val_b : val_a;

  always @(posedge clk) begin
    if ((a_rd || a_wr) && wleft != 0) wleft <= wleft - 1;
    if (a_rd && !wreq)                rdv_cnt <= rlat;
    else if (rdv_cnt != 0)            rdv_cnt <= rdv_cnt - 1;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int cnt_model(input int i, input int k, input int lat);
    if (i == 0) return 3;
    if (i <= k) return (3 - i < 1) ? 1 : 3 - i;
    if (i <= k + lat) return 1;
    return 0;
  endfunction

  // one transaction; per-cycle checks of countdown, strobes and bus address
  task automatic run_txn(input bit rd, input bit wr, input logic [AW-1:0] a,
                         input logic [DW-1:0] d, input int k, input int lat,
                         input logic [DW-1:0] va, input logic [DW-1:0] vb,
                         input bit poke);
    int last;
    @(negedge clk);
    wleft = k; rlat = lat; val_a = va; val_b = vb;
    req_rd = rd; req_wr = wr; req_addr = a; req_wdata = d;
    last = rd ? k + lat + 1 : k + 1;
    for (int i = 0; i <= last + 1; i++) begin
      @(negedge clk);
      req_rd = 1'b0; req_wr = 1'b0; req_addr = ~a; req_wdata = ~d;
      chk(a_cnt == 2'(cnt_model(i, k, rd ? lat : 0)), "R3/R4/R6", "u0 count", 64'(a_cnt),
          64'(cnt_model(i, k, rd ? lat : 0)));
      chk(b_cnt == 2'(cnt_model(i, k, 0)), "R3/R4", "u1 count", 64'(b_cnt),
          64'(cnt_model(i, k, 0)));
      if (i <= k) begin
        chk(a_addr == a && b_addr == a, "R1/R2/R8", "bus address", 64'(a_addr), 64'(a));
        chk(a_rd == rd && b_rd == rd, "R1/R2/R9", "read strobe", 64'(a_rd), 64'(rd));
        chk(a_wr == !rd && b_wr == !rd, "R1/R2/R9", "write strobe", 64'(a_wr), 64'(!rd));
        if (!rd) chk(a_wd == d && b_wd == d, "R1/R2", "write data", 64'(a_wd), 64'(d));
      end else begin
        chk(!a_rd && !a_wr && !b_rd && !b_wr, "R4/R8", "strobes low after accept",
            64'({a_rd, a_wr, b_rd, b_wr}), 64'(0));
      end
      if (poke && i == 1) begin
        req_rd = 1'b1; req_addr = a ^ 24'h5a5a5a;  // R8: arrives while busy
      end
    end
    if (rd) begin
      chk(a_rdata == vb, "R6", "latency-aware read data", 64'(a_rdata), 64'(vb));
      chk(b_rdata == va, "R5", "plain read data", 64'(b_rdata), 64'(va));
    end
  endtask

  task automatic test_reset;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!a_rd && !a_wr && !b_rd && !b_wr, "R10", "strobes after reset",
        64'({a_rd, a_wr, b_rd, b_wr}), 64'(0));
    chk(a_cnt == 0 && b_cnt == 0, "R10", "count after reset", 64'(a_cnt), 64'(0));
    chk(a_rdata == 0 && b_rdata == 0, "R10", "rdata after reset", 64'(a_rdata), 64'(0));
  endtask

  task automatic test_read_fast;    // R5 R6: no stall, valid one cycle later
    run_txn(1'b1, 1'b0, 24'h000100, 32'h0, 0, 1, 32'h1111_aaaa, 32'h2222_bbbb, 1'b0);
  endtask

  task automatic test_write_stall;  // R2 R4: two stall cycles
    run_txn(1'b0, 1'b1, 24'h00abcd, 32'hcafe_f00d, 2, 1, 32'h0, 32'h0, 1'b0);
  endtask

  task automatic test_hold;         // R7: data survives write and idle time
    repeat (4) @(negedge clk);
    chk(a_rdata == 32'h2222_bbbb, "R7", "u0 rdata held", 64'(a_rdata), 64'h2222_bbbb);
    chk(b_rdata == 32'h1111_aaaa, "R7", "u1 rdata held", 64'(b_rdata), 64'h1111_aaaa);
  endtask

  task automatic test_busy_poke;    // R8: request during a stalled read
    run_txn(1'b1, 1'b0, 24'h0f0f0f, 32'h0, 3, 2, 32'h3333_cccc, 32'h4444_dddd, 1'b1);
  endtask

  task automatic test_both;         // R9: read wins over write
    run_txn(1'b1, 1'b1, 24'h123456, 32'hdead_beef, 1, 1, 32'h5555_eeee, 32'h6666_ffff, 1'b0);
  endtask

  task automatic test_long_stall;   // R3: floor of 1 under a long stall
    run_txn(1'b1, 1'b0, 24'hfffffe, 32'h0, 5, 3, 32'h7777_0001, 32'h8888_0002, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nbad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

  initial begin
    test_reset();
    test_read_fast();
    test_write_stall();
    test_hold();
    test_busy_poke();
    test_both();
    test_long_stall();
    repeat (2) @(negedge clk);
    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule